// File: doc/BRIEF.md
# Integer ALU Status Flag Unit

This block sits next to a 32-bit integer adder/subtractor and logic unit. Each cycle it sees the two operands, a three-bit operation code and the result the datapath produced. From these it derives six condition flags: carry/borrow, low-byte parity, nibble carry, zero, sign and signed overflow. It packs them at fixed positions into a 32-bit status word. The flags are written on the clock edge when the update enable is high and hold otherwise.

A compare sets the flags exactly as a subtract of the second operand from the first would. It keeps the write-back strobe low, so no destination is written. The logic operations (AND, OR, NOT) set zero, sign and parity from the result and force carry, overflow and nibble carry to 0. Two control bits share the status word. They are plain storage with their own write strobe, and the block never interprets them.

Updates arrive as a plain enable, not a handshake. The unit accepts one update every cycle, so there is no back-pressure.

Top module: `alu_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, `status_word` equals 0x00000002.
- R2: Bit 1 of `status_word` always reads 1. Bits 3, 5, 8 and 12 to 31 always read 0.
- R3: `op_sel` codes are 0 add, 1 subtract, 2 compare, 3 AND, 4 OR and 5 NOT. On an update, bit 0 (carry) is set when an add carries out of bit 31, or when a subtract or compare borrows (first operand below second, unsigned).
- R4: On an update, bit 2 (parity) is set when bits 7:0 of `result` hold an even number of ones.
- R5: On an update, bit 4 (nibble carry) is set when an add carries out of bit 3, or when a subtract or compare borrows into bit 3.
- R6: On an update, bit 6 (zero) is set exactly when `result` is all zeros.
- R7: On an update, bit 7 (sign) equals bit 31 of `result`.
- R8: On an update, bit 11 (overflow) is set when a signed add or subtract/compare result does not fit in 32 bits.
- R9: A compare gives the same flags as a subtract of `op_b` from `op_a`, and `wb_en` stays low for it. For codes 0, 1, 3, 4 and 5 with `upd_en` high, `wb_en` is high in the same cycle.
- R10: AND, OR and NOT updates clear bits 0, 4 and 11.
- R11: With `upd_en` low, or with `op_sel` 6 or 7, the flags keep their value and `wb_en` is low.
- R12: When `ctl_we` is high, bits 10:9 take `ctl_wdata[1:0]` at the clock edge. Flag updates never alter them, and control writes never alter the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Flag update enable for this cycle's operation |
| op_sel | input | 3 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| result | input | 32 | Datapath result for this operation |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_wdata | input | 2 | Control bit value (bit 0 to word bit 9, bit 1 to word bit 10) |
| wb_en | output | 1 | Result write-back strobe (combinational) |
| status_word | output | 32 | Packed registered status word |

## Verification
`wb_en` is combinational, so it is checked in the same cycle as the stimulus. Inputs are driven at the falling edge and `wb_en` is sampled a moment later. Every flag and control bit in `status_word` passes through one register, so it is due one rising edge after the stimulus. The bench therefore drives at one falling edge and compares the whole word at the next falling edge. Hold cases wait at least two edges before comparing, so a spurious update would have had time to show.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;
  localparam int DATA_W  = 32;
  localparam int STAT_W  = 32;
  localparam int NIB_MSB = 3;
  localparam int PAR_W   = 8;

  localparam int CF_POS  = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int CT0_POS = 9;
  localparam int CT1_POS = 10;
  localparam int OF_POS  = 11;
  localparam int CTL_W   = 2;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CMP = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;
  localparam logic [2:0] OP_NOT = 3'd5;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } flags_t;
endpackage

// File: rtl/arith_flags.sv
module arith_flags #(
  parameter int W   = 32,
  parameter int NIB = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         is_arith,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int LW = NIB + 1;

  logic [W:0]  wide;
  logic [LW:0] low;
  logic        sgn_r;

  always_comb begin
    if (is_sub) begin
      wide = {1'b0, a} - {1'b0, b};
      low  = {1'b0, a[NIB:0]} - {1'b0, b[NIB:0]};
    end else begin
      wide = {1'b0, a} + {1'b0, b};
      low  = {1'b0, a[NIB:0]} + {1'b0, b[NIB:0]};
    end
    sgn_r = wide[W-1];
    cf = is_arith & wide[W];
    af = is_arith & low[LW];
    if (is_sub)
      of = is_arith & (a[W-1] != b[W-1]) & (sgn_r != a[W-1]);
    else
      of = is_arith & (a[W-1] == b[W-1]) & (sgn_r != a[W-1]);
  end
endmodule

// File: rtl/result_flags.sv
module result_flags #(
  parameter int W  = 32,
  parameter int PW = 8
) (
  input  logic [W-1:0] res,
  output logic         zf,
  output logic         sf,
  output logic         pf
);
  always_comb begin
    zf = (res == '0);
    sf = res[W-1];
    pf = ~(^res[PW-1:0]);
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import aluflag_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_we,
  input  logic             logic_op,
  input  flags_t           flags_in,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_in,
  output logic [SW-1:0]    status_o
);
  flags_t           flags_q;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ctl_q   <= '0;
    end else begin
      if (flag_we) flags_q <= flags_in;
      if (ctl_we)  ctl_q   <= ctl_in;
    end
  end

  for (genvar i = 0; i < SW; i++) begin : g_pack
    if (i == CF_POS)       begin : g_cf assign status_o[i] = flags_q.cf; end
    else if (i == ONE_POS) begin : g_on assign status_o[i] = 1'b1; end
    else if (i == PF_POS)  begin : g_pf assign status_o[i] = flags_q.pf; end
    else if (i == AF_POS)  begin : g_af assign status_o[i] = flags_q.af; end
    else if (i == ZF_POS)  begin : g_zf assign status_o[i] = flags_q.zf; end
    else if (i == SF_POS)  begin : g_sf assign status_o[i] = flags_q.sf; end
    else if (i == CT0_POS) begin : g_c0 assign status_o[i] = ctl_q[0]; end
    else if (i == CT1_POS) begin : g_c1 assign status_o[i] = ctl_q[1]; end
    else if (i == OF_POS)  begin : g_of assign status_o[i] = flags_q.of; end
    else                   begin : g_z  assign status_o[i] = 1'b0; end
  end

  // R2: fixed bits
  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ONE_POS] && !status_o[3] && !status_o[5] && !status_o[8] && (status_o[SW-1:12] == '0));

  // R11: hold when nothing is written
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && !ctl_we) |=> $stable(status_o));

  // R10: logic operations clear carry, nibble carry and overflow
  assert_logic_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && logic_op) |=> (!status_o[CF_POS] && !status_o[AF_POS] && !status_o[OF_POS]));

  // R12: control bits untouched by flag-only updates
  assert_ctl_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we) |=> $stable(status_o[CT1_POS:CT0_POS]));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import aluflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] result,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              wb_en,
  output logic [STAT_W-1:0] status_word
);
  logic   is_sub, is_arith, is_logic, op_ok, flag_we;
  logic   a_cf, a_af, a_of, r_zf, r_sf, r_pf;
  flags_t nxt;

  always_comb begin
    is_sub   = (op_sel == OP_SUB) || (op_sel == OP_CMP);
    is_arith = is_sub || (op_sel == OP_ADD);
    is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_NOT);
    op_ok    = is_arith || is_logic;
    flag_we  = upd_en && op_ok;
    wb_en    = flag_we && (op_sel != OP_CMP);
  end

  arith_flags #(.W(DATA_W), .NIB(NIB_MSB)) u_arith (
    .a(op_a), .b(op_b), .is_sub(is_sub), .is_arith(is_arith),
    .cf(a_cf), .af(a_af), .of(a_of)
  );

  result_flags #(.W(DATA_W), .PW(PAR_W)) u_res (
    .res(result), .zf(r_zf), .sf(r_sf), .pf(r_pf)
  );

  always_comb begin
    nxt.cf = a_cf;
    nxt.af = a_af;
    nxt.of = a_of;
    nxt.zf = r_zf;
    nxt.sf = r_sf;
    nxt.pf = r_pf;
  end

  status_reg #(.SW(STAT_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .logic_op(is_logic),
    .flags_in(nxt), .ctl_we(ctl_we), .ctl_in(ctl_wdata), .status_o(status_word)
  );

  // R9: compare never writes back
  assert_cmp_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_sel == OP_CMP) |-> !wb_en);

  // R6: zero flag follows the registered result
  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_ok) |=> (status_word[ZF_POS] == ($past(result) == '0)));

  // R7: sign flag follows result top bit
  assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_ok) |=> (status_word[SF_POS] == $past(result[DATA_W-1])));

  // R11: reserved codes do not write back
  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[2:1] == 2'b11) |-> !wb_en);
endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // {a, b, op, result, expected status word}
  localparam logic [130:0] VEC [NV] = '{
    {32'hFFFFFFFF, 32'h00000001, 3'd0, 32'h00000000, 32'h00000057}, // R3 R4 R5 R6 carry wrap
    {32'h7FFFFFFF, 32'h00000001, 3'd0, 32'h80000000, 32'h00000896}, // R8 R7 positive overflow
    {32'h00000005, 32'h00000007, 3'd1, 32'hFFFFFFFE, 32'h00000093}, // R3 R5 borrow
    {32'h80000000, 32'h00000001, 3'd2, 32'h7FFFFFFF, 32'h00000816}, // R9 R8 compare
    {32'h00000000, 32'h00000001, 3'd1, 32'hFFFFFFFF, 32'h00000097}, // R3 R4 R5
    {32'hF0F0F0F0, 32'h0F0F0F0F, 3'd3, 32'h00000000, 32'h00000046}, // R10 AND
    {32'h80000000, 32'h00000003, 3'd4, 32'h80000003, 32'h00000086}, // R10 OR
    {32'h00000007, 32'h00000000, 3'd5, 32'hFFFFFFF8, 32'h00000082}, // R10 NOT odd parity
    {32'h00000010, 32'h00000010, 3'd1, 32'h00000000, 32'h00000046}, // R6 sub to zero
    {32'h00000008, 32'h00000008, 3'd0, 32'h00000010, 32'h00000012}  // R5 nibble carry
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        upd_en = 0;
  logic [2:0]  op_sel = 0;
  logic [31:0] op_a = 0, op_b = 0, result = 0;
  logic        ctl_we = 0;
  logic [1:0]  ctl_wdata = 0;
  logic        wb_en;
  logic [31:0] status_word;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  alu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel), .op_a(op_a),
    .op_b(op_b), .result(result), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .wb_en(wb_en), .status_word(status_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                       input logic [31:0] r, input logic en);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; result = r; upd_en = en;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", status_word, 32'h00000002);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][130:99], VEC[i][98:67], VEC[i][66:64], VEC[i][63:32], 1'b1);
      #1;
      check("R9 wb_en", {31'b0, wb_en}, {31'b0, VEC[i][66:64] != 3'd2});
      @(negedge clk);
      upd_en = 0;
      check($sformatf("R2-R10 vector %0d", i), status_word, VEC[i][31:0]);
    end

    // R11: enable low holds flags (last word 0x12)
    apply(32'hFFFFFFFF, 32'h1, 3'd0, 32'h0, 1'b0);
    #1 check("R11 wb_en low without enable", {31'b0, wb_en}, 32'h0);
    repeat (2) @(negedge clk);
    check("R11 hold with enable low", status_word, 32'h00000012);

    // R11: reserved codes 6 and 7
    apply(32'h0, 32'h0, 3'd6, 32'h0, 1'b1);
    #1 check("R11 wb_en low op 6", {31'b0, wb_en}, 32'h0);
    apply(32'h0, 32'h0, 3'd7, 32'h0, 1'b1);
    #1 check("R11 wb_en low op 7", {31'b0, wb_en}, 32'h0);
    @(negedge clk);
    upd_en = 0;
    check("R11 reserved ops hold", status_word, 32'h00000012);

    // R12: control bits written alone
    @(negedge clk);
    ctl_we = 1; ctl_wdata = 2'b11;
    @(negedge clk);
    ctl_we = 0;
    check("R12 control write", status_word, 32'h00000612);

    // R12: flag update keeps control bits (0 + 0 = 0)
    apply(32'h0, 32'h0, 3'd0, 32'h0, 1'b1);
    @(negedge clk);
    upd_en = 0;
    check("R12 flags update keeps control", status_word, 32'h00000646);

    // R12: control write keeps flags
    ctl_we = 1; ctl_wdata = 2'b01;
    @(negedge clk);
    ctl_we = 0;
    check("R12 control write keeps flags", status_word, 32'h00000246);

    // R1: reset clears flags and control bits
    rst_n = 0;
    @(negedge clk);
    check("R1 reset after activity", status_word, 32'h00000002);
    rst_n = 1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule